// File: doc/BRIEF.md
# Predicated Vector Rounding Shift Unit

This block is a SIMD datapath for a vector register made of packed 8-bit unsigned lanes. Every lane is shifted right by the same immediate amount, with rounding to nearest (halves round up). The lanes are computed independently and in parallel. A per-lane predicate picks which lanes are written. A lane whose predicate bit is clear keeps its previous destination contents. The destination register is also the first source, so that value is the incoming source byte.

The vector width is a parameter: a multiple of 128 bits from 128 to 2048, giving 16 to 256 lanes. Each lane uses the predicate bit at its own byte index. A strobe launches one operation. The merged result is registered and appears one cycle later, together with a one-cycle valid pulse. A shift immediate outside 1..8 is illegal. It raises an error flag alongside the valid pulse and leaves the whole vector unchanged.

Top module: `vec_round_shr`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` and `res_err` are 0 and `res_vec` is all zeros.
- R2: `res_valid` is 1 in exactly the cycle after a cycle in which `op_valid` was 1, and is 0 otherwise.
- R3: For a legal shift `s` (1 to 8) and a set predicate bit, output byte i equals `(x + 2^(s-1)) >> s`, where x is source byte i (bits 8i+7..8i). The sum is evaluated in wider arithmetic.
- R4: The rounding add never wraps. Source 0xFF with shift 1 gives 0x80, and 0xFF with shift 8 gives 0x01.
- R5: A shift of 8 yields 1 when bit 7 of the source byte is set, and 0 when it is clear.
- R6: A lane whose predicate bit (`op_pred[i]` for byte i) is 0 outputs its source byte unchanged.
- R7: A shift code of 0 or of 9 to 15 raises `res_err` together with `res_valid`. The output vector then equals the source vector regardless of the predicate. With a legal shift, `res_err` is 0.
- R8: In a cycle without a valid pulse, `res_vec` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Strobe that launches one operation |
| op_vec | input | VEC_BITS | Source and old destination vector, byte i in bits 8i+7..8i |
| op_pred | input | VEC_BITS/8 | Predicate, one bit per byte lane |
| op_shift | input | 4 | Shift immediate, legal range 1 to 8 |
| res_valid | output | 1 | Pulses one cycle after `op_valid` |
| res_vec | output | VEC_BITS | Registered merged result |
| res_err | output | 1 | Illegal shift flag, valid with `res_valid` |

## Verification
For every legal shift, the bench sweeps all 256 byte values. A design that adds at 8 bits is caught at 0xFF and near the top of the range, where the output wraps to a small value. A design that mishandles a shift of 8 returns 0 for every input, or drops the carry into bit 8. Predicate masks include none, all, alternating and irregular patterns. A design that zeroes inactive lanes, or reads the predicate at the wrong index, shows wrong bytes in exactly those lanes. All illegal codes are driven. A design that masks the shift to three bits, or writes the rounded value anyway, shows up through the error flag or changed bytes. After each result the bench also checks that the output holds.

// File: rtl/vec_round_shr.sv
module vec_round_shr #(
  parameter int VEC_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [VEC_BITS-1:0]   op_vec,
  input  logic [VEC_BITS/8-1:0] op_pred,
  input  logic [3:0]            op_shift,
  output logic                  res_valid,
  output logic [VEC_BITS-1:0]   res_vec,
  output logic                  res_err
);
  localparam int LANES = VEC_BITS / 8;

  initial begin
    if (VEC_BITS % 128 != 0 || VEC_BITS < 128 || VEC_BITS > 2048)
      $error("VEC_BITS must be a multiple of 128 in 128..2048");
  end

  logic                shift_ok;
  logic [VEC_BITS-1:0] merged;

  assign shift_ok = (op_shift != 4'd0) && (op_shift <= 4'd8);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [8:0] sum;
    logic [7:0] rounded;
    assign sum     = {1'b0, op_vec[8*i +: 8]} + (9'd1 << (op_shift - 4'd1));
    assign rounded = 8'(sum >> op_shift);
    assign merged[8*i +: 8] = (shift_ok && op_pred[i]) ? rounded : op_vec[8*i +: 8];

    p_inactive_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_pred[i]) |=> (res_vec[8*i +: 8] == $past(op_vec[8*i +: 8])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_vec   <= '0;
    end else begin
      res_valid <= op_valid;
      res_err   <= op_valid && !shift_ok;
      if (op_valid) res_vec <= merged;
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_valid_only_after_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  p_err_with_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> res_valid);
  p_err_unchanged_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_shift == 4'd0 || op_shift > 4'd8)) |=> (res_err && res_vec == $past(op_vec)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_vec));
endmodule

// File: tb/tb_vec_round_shr.sv
module tb_vec_round_shr;
  localparam int VB = 128;
  localparam int NL = VB / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [VB-1:0] op_vec = '0;
  logic [NL-1:0] op_pred = '0;
  logic [3:0]    op_shift = 4'd1;
  logic          res_valid;
  logic [VB-1:0] res_vec;
  logic          res_err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vec_round_shr #(.VEC_BITS(VB)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_vec(op_vec),
    .op_pred(op_pred), .op_shift(op_shift),
    .res_valid(res_valid), .res_vec(res_vec), .res_err(res_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [VB-1:0] act, input logic [VB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [VB-1:0] model(input logic [VB-1:0] v, input logic [NL-1:0] p,
                                          input int s);
    logic [VB-1:0] r;
    for (int i = 0; i < NL; i++) begin
      int x;
      x = int'(v[8*i +: 8]);
      if (s >= 1 && s <= 8 && p[i]) r[8*i +: 8] = 8'((x + (1 << (s - 1))) >> s);
      else r[8*i +: 8] = v[8*i +: 8];
    end
    return r;
  endfunction

  task automatic run(input logic [VB-1:0] v, input logic [NL-1:0] p, input int s,
                     input string req);
    logic [VB-1:0] exp;
    logic [VB-1:0] held;
    exp = model(v, p, s);
    @(negedge clk);
    op_vec = v; op_pred = p; op_shift = 4'(s); op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    op_vec = ~v; op_pred = ~p;
    check(res_valid == 1'b1, "R2", "valid pulse", VB'(res_valid), VB'(1));
    check(res_vec == exp, req, $sformatf("data s=%0d", s), res_vec, exp);
    check(res_err == (s < 1 || s > 8), "R7", "error flag", VB'(res_err), VB'(s < 1 || s > 8));
    held = res_vec;
    @(negedge clk);
    check(res_valid == 1'b0, "R2", "valid drops", VB'(res_valid), VB'(0));
    check(res_vec == held, "R8", "hold", res_vec, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [VB-1:0] v;
    logic [NL-1:0] p;
    repeat (2) @(negedge clk);
    check(res_valid == 0 && res_err == 0 && res_vec == '0, "R1", "in reset", res_vec, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 0 && res_err == 0 && res_vec == '0, "R1", "after reset", res_vec, '0);

    // R3 exhaustive bytes per legal shift, all lanes active
    for (int s = 1; s <= 8; s++)
      for (int b = 0; b < 256 / NL; b++) begin
        for (int i = 0; i < NL; i++) v[8*i +: 8] = 8'(b * NL + i);
        run(v, '1, s, "R3");
      end

    // R4 no wrap
    run({NL{8'hFF}}, '1, 1, "R4");
    check(res_vec[7:0] == 8'h80, "R4", "FF>>1", VB'(res_vec[7:0]), VB'(8'h80));
    run({NL{8'hFF}}, '1, 8, "R4");
    run({NL{8'h00}}, '1, 4, "R3");

    // R5 shift of 8 by bit 7
    for (int i = 0; i < NL; i++) v[8*i +: 8] = (i % 2) ? 8'h80 : 8'h7F;
    run(v, '1, 8, "R5");

    // R6 predicate patterns
    for (int s = 1; s <= 8; s++) begin
      for (int i = 0; i < NL; i++) v[8*i +: 8] = 8'($urandom);
      run(v, '0, s, "R6");
      run(v, {(NL/2){2'b01}}, s, "R6");
      p = NL'($urandom);
      run(v, p, s, "R6");
      run({NL{8'hFF}}, p, s, "R6");
    end

    // R7 illegal codes
    for (int s = 0; s < 16; s++) begin
      if (s >= 1 && s <= 8) continue;
      for (int i = 0; i < NL; i++) v[8*i +: 8] = 8'($urandom);
      run(v, '1, s, "R7");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule